// File: doc/BRIEF.md
# NOR Flash Program Command Engine

This block models the command side of a parallel NOR flash. A host issues bus write cycles of address and data. The low byte of the data is decoded as a command, and two program flows are supported. In single-word programming, a command write is followed by one address/data write. In buffered programming, a setup command is followed by a word count written as N-1, then N address/data writes into a 32-entry buffer, then a confirm command. A confirmed operation runs as a timed write into an internal array of `2**AW` words. Each word takes `PROG_CYC` clock cycles, or twice that when the buffer runs across a 32-word boundary. Programming can only clear bits.

The host reads through a combinational port. Once any program command has been written, reads return the status byte until a read-array command is written. Blocks of `2**BLKW` words can be write-protected through a lock input. Errors are recorded in sticky status bits. Driving the active-low reset aborts any operation in progress.

The block has no stream data path: every write is one bus beat taken on the clock edge where `wr_en` is high, and there is no back-pressure. A write that cannot be used in the current state is dropped. The host learns the state through status bit 7 or through `prog_ready`.

Top module: `nor_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset is released, the block is in read-array mode, every array word reads 0xFFFF, `prog_ready` is 1, and the status byte is 0x80. Asserting `rst_n` low during programming aborts the operation at once.
- R2: Writing command 0x40 followed by an address/data write programs that word to (old AND data). `prog_ready` is low for exactly `PROG_CYC` cycles, starting from the edge that took the data write.
- R3: After command 0x40 or 0xE8, reads return {zeros, status byte} until command 0xFF is written; command 0x70 also selects the status view. Status byte layout: bit 7 = ready, bit 5 = sequence error, bit 4 = program error, bit 1 = lock error, all other bits 0.
- R4: A single-word write to a word in a locked block (block index = address >> BLKW, locked when `lock_mask` bit is 1) leaves the array unchanged, does not start programming, and sets status bits 1 and 4.
- R5: Command 0xE8 written while programming is in progress is ignored, and status bit 7 reads 0. The next write after such a setup is decoded as a command.
- R6: A word count above 0x1F written after 0xE8 aborts the operation: status bits 4 and 5 are set and the array is unchanged.
- R7: With count C (0 to 31), the next C+1 writes fill the buffer. After confirm 0xD0, each word is programmed at its own fill address, and `prog_ready` stays low for (C+1)·`PROG_CYC` cycles.
- R8: After the buffer is full, a write other than 0xD0 sets status bits 4 and 5, programs nothing, and returns to command decoding. A fill address outside [start, start+C] gives the same result at confirm.
- R9: When (start mod 32) + C > 31, each word takes 2·`PROG_CYC` cycles.
- R10: Error bits 1, 4 and 5 stay set until command 0x50 clears them. Command 0x50 leaves bit 7 unchanged.
- R11: While programming, array reads return 0x0000. After completion they return the programmed value.
- R12: A confirmed buffer containing any word in a locked block programs nothing and sets status bits 1 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts programming |
| wr_en | input | 1 | Bus write strobe, one beat per cycle high |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data; bits [7:0] carry command codes |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Status byte or array word, combinational |
| lock_mask | input | 2**(AW-BLKW) | Per-block write protect, 1 = locked |
| prog_ready | output | 1 | 1 when no program operation runs (mirrors status bit 7) |

## Verification
The bench builds the block with AW=6, BLKW=4 and PROG_CYC=3. This gives a 64-word array split into four 16-word blocks, so every address can be programmed and read back in a sweep. It also makes every buffer count from 0 to 31 cheap to run, and a single buffer can reach both a 32-word boundary and a locked block. The bench keeps a model of the array, computed as successive ANDs. It derives busy durations from the count and the alignment of the start address, including the exact boundary cases where the start offset is 30 and 31.

// File: rtl/nor_pkg.sv
package nor_pkg;
  localparam int BUF_WORDS = 32;
  localparam int CW        = 5;

  localparam logic [7:0] OP_WORD  = 8'h40;
  localparam logic [7:0] OP_SETUP = 8'hE8;
  localparam logic [7:0] OP_GO    = 8'hD0;
  localparam logic [7:0] OP_ARRAY = 8'hFF;
  localparam logic [7:0] OP_STAT  = 8'h70;
  localparam logic [7:0] OP_CLR   = 8'h50;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_WORD,
    ST_COUNT,
    ST_FILL,
    ST_CONF
  } cmd_st_t;
endpackage

// File: rtl/nor_wbuf.sv
module nor_wbuf
  import nor_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [CW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] ridx,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [AW-1:0] addr_mem [BUF_WORDS];
  logic [DW-1:0] data_mem [BUF_WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      data_mem[widx] <= wdata;
    end
  end

  assign raddr = addr_mem[ridx];
  assign rdata = data_mem[ridx];
endmodule

// File: rtl/nor_array.sv
module nor_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NW = 2 ** AW;

  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= '1;
    end else if (we) begin
      mem[waddr] <= mem[waddr] & wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/nor_prog_eng.sv
module nor_prog_eng
  import nor_pkg::*;
#(
  parameter int PROG_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] cnt_in,
  input  logic          slow_in,
  output logic          busy,
  output logic [CW-1:0] ridx,
  output logic          arr_we
);
  localparam int TW = $clog2(2 * PROG_CYC + 1);
  localparam logic [TW-1:0] LIM_FAST = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] LIM_SLOW = TW'(2 * PROG_CYC - 1);

  logic          busy_q;
  logic          slow_q;
  logic [CW-1:0] pidx_q;
  logic [CW-1:0] last_q;
  logic [TW-1:0] timer_q;
  logic [TW-1:0] limit;

  assign limit = slow_q ? LIM_SLOW : LIM_FAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      slow_q  <= 1'b0;
      pidx_q  <= '0;
      last_q  <= '0;
      timer_q <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      slow_q  <= slow_in;
      pidx_q  <= '0;
      last_q  <= cnt_in;
      timer_q <= '0;
    end else if (busy_q) begin
      if (timer_q == limit) begin
        timer_q <= '0;
        if (pidx_q == last_q) busy_q <= 1'b0;
        else                  pidx_q <= pidx_q + 1'b1;
      end else begin
        timer_q <= timer_q + 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign ridx   = pidx_q;
  assign arr_we = busy_q && (timer_q == limit);

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q); // R5
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q); // R2
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (timer_q <= limit)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pidx_q <= last_q)); // R7
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BLKW = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [2**(AW-BLKW)-1:0] lock_mask,
  input  logic                    busy,
  output logic                    show_stat,
  output logic                    err_seq,
  output logic                    err_prog,
  output logic                    err_lock,
  output logic                    start,
  output logic [CW-1:0]           cnt_o,
  output logic                    slow_o,
  output logic                    bw_en,
  output logic [CW-1:0]           bw_idx
);
  cmd_st_t       st_q;
  logic [CW-1:0] cnt_q, idx_q;
  logic [AW-1:0] base_q, off;
  logic          slow_q, lk_hit_q, rng_bad_q;
  logic          locked, go_ok;
  logic [7:0]    op;

  assign op     = wr_data[7:0];
  assign locked = lock_mask[wr_addr[AW-1:BLKW]];
  assign off    = wr_addr - base_q;
  assign go_ok  = (op == OP_GO) && !rng_bad_q && !lk_hit_q;

  assign start  = wr_en && (((st_q == ST_WORD) && !locked) ||
                            ((st_q == ST_CONF) && go_ok));
  assign cnt_o  = (st_q == ST_WORD) ? '0 : cnt_q;
  assign slow_o = (st_q == ST_WORD) ? 1'b0 : slow_q;
  assign bw_en  = wr_en && ((st_q == ST_FILL) || ((st_q == ST_WORD) && !locked));
  assign bw_idx = (st_q == ST_FILL) ? idx_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_CMD;
      show_stat <= 1'b0;
      err_seq   <= 1'b0;
      err_prog  <= 1'b0;
      err_lock  <= 1'b0;
      cnt_q     <= '0;
      idx_q     <= '0;
      base_q    <= '0;
      slow_q    <= 1'b0;
      lk_hit_q  <= 1'b0;
      rng_bad_q <= 1'b0;
    end else if (wr_en) begin
      unique case (st_q)
        ST_CMD: begin
          if (op == OP_WORD) begin
            show_stat <= 1'b1;
            if (!busy) st_q <= ST_WORD;
          end else if (op == OP_SETUP) begin
            show_stat <= 1'b1;
            if (!busy) st_q <= ST_COUNT;
          end else if (op == OP_ARRAY) begin
            show_stat <= 1'b0;
          end else if (op == OP_STAT) begin
            show_stat <= 1'b1;
          end else if (op == OP_CLR) begin
            err_seq  <= 1'b0;
            err_prog <= 1'b0;
            err_lock <= 1'b0;
          end
        end
        ST_WORD: begin
          if (locked) begin
            err_lock <= 1'b1;
            err_prog <= 1'b1;
          end
          st_q <= ST_CMD;
        end
        ST_COUNT: begin
          if (wr_data > DW'(BUF_WORDS - 1)) begin
            err_seq  <= 1'b1;
            err_prog <= 1'b1;
            st_q     <= ST_CMD;
          end else begin
            cnt_q     <= wr_data[CW-1:0];
            base_q    <= wr_addr;
            slow_q    <= ({1'b0, wr_addr[4:0]} + {1'b0, wr_data[4:0]}) > 6'd31;
            idx_q     <= '0;
            lk_hit_q  <= 1'b0;
            rng_bad_q <= 1'b0;
            st_q      <= ST_FILL;
          end
        end
        ST_FILL: begin
          lk_hit_q  <= lk_hit_q | locked;
          rng_bad_q <= rng_bad_q | (off > AW'(cnt_q));
          if (idx_q == cnt_q) st_q <= ST_CONF;
          else                idx_q <= idx_q + 1'b1;
        end
        ST_CONF: begin
          if (op != OP_GO || rng_bad_q) begin
            err_seq  <= 1'b1;
            err_prog <= 1'b1;
          end else if (lk_hit_q) begin
            err_lock <= 1'b1;
            err_prog <= 1'b1;
          end
          st_q <= ST_CMD;
        end
        default: st_q <= ST_CMD;
      endcase
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |-> (idx_q <= cnt_q)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_prog && !(wr_en && st_q == ST_CMD && op == OP_CLR)) |=> err_prog); // R10
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_q == ST_WORD && locked) |=> (err_lock && err_prog)); // R4
  AST_SEQ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_seq) |-> err_prog); // R8
endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
  import nor_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int BLKW     = 5,
  parameter int PROG_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [AW-1:0]           rd_addr,
  output logic [DW-1:0]           rd_data,
  input  logic [2**(AW-BLKW)-1:0] lock_mask,
  output logic                    prog_ready
);
  logic          busy, show_stat, err_seq, err_prog, err_lock;
  logic          start, slow, bw_en, arr_we;
  logic [CW-1:0] cnt, bw_idx, ridx;
  logic [AW-1:0] b_addr;
  logic [DW-1:0] b_data, arr_q;
  logic [7:0]    stat;

  nor_cmd_fsm #(.AW(AW), .DW(DW), .BLKW(BLKW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock_mask(lock_mask), .busy(busy),
    .show_stat(show_stat), .err_seq(err_seq), .err_prog(err_prog),
    .err_lock(err_lock), .start(start), .cnt_o(cnt), .slow_o(slow),
    .bw_en(bw_en), .bw_idx(bw_idx)
  );

  nor_wbuf #(.AW(AW), .DW(DW)) u_buf (
    .clk(clk), .we(bw_en), .widx(bw_idx), .waddr(wr_addr), .wdata(wr_data),
    .ridx(ridx), .raddr(b_addr), .rdata(b_data)
  );

  nor_prog_eng #(.PROG_CYC(PROG_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt), .slow_in(slow),
    .busy(busy), .ridx(ridx), .arr_we(arr_we)
  );

  nor_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(b_addr), .wdata(b_data),
    .raddr(rd_addr), .rdata(arr_q)
  );

  assign stat       = {~busy, 1'b0, err_seq, err_prog, 2'b00, err_lock, 1'b0};
  assign prog_ready = ~busy;
  assign rd_data    = show_stat ? {{(DW-8){1'b0}}, stat} :
                      (busy ? '0 : arr_q);

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $stable(lock_mask)) |-> !lock_mask[wr_addr[AW-1:BLKW]] || !bw_en); // R12
endmodule

// File: tb/sim_nor_prog_ctrl.sv
module sim_nor_prog_ctrl;
  localparam int AW = 6, DW = 16, BLKW = 4, PC = 3;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, prog_ready;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [3:0]    lock_mask = 4'b0000;

  logic [15:0] model [64];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nor_prog_ctrl #(.AW(AW), .DW(DW), .BLKW(BLKW), .PROG_CYC(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .lock_mask(lock_mask), .prog_ready(prog_ready)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    wr_addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_addr = AW'(a); #1; d = rd_data;
  endtask

  task automatic wait_ready(output int c);
    c = 0;
    while (!prog_ready) begin c++; @(negedge clk); end
  endtask

  task automatic stat_is(input string req, input logic [15:0] exp);
    logic [15:0] v;
    wr(0, 16'h0070); rd(0, v); chk(req, v, exp);
  endtask

  task automatic arr_is(input string req, input int a);
    logic [15:0] v;
    wr(0, 16'h00FF); rd(a, v); chk(req, v, model[a]);
  endtask

  function automatic logic [15:0] bdat(input int k, input int s);
    return ~(16'h0001 << ((k + s) % 16)) & ~(16'(s) << 8);
  endfunction

  // fill C+1 words in descending address order ending at base
  task automatic buf_run(input int base, input int c, input int s, input int bad_off,
                         input logic [7:0] conf, input bit apply);
    wr(base, 16'h00E8);
    wr(base, 16'(c));
    for (int k = 0; k <= c; k++) begin
      int a = (k == 0 && bad_off != 0) ? (base + bad_off) % 64 : (base + c - k) % 64;
      wr(a, bdat(k, s));
      if (apply) model[a] = model[a] & bdat(k, s);
    end
    wr(base, {8'h00, conf});
  endtask

  initial begin
    logic [15:0] v;
    int c;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {15'd0, prog_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 64; a++) begin rd(a, v); chk("R1 erased", v, 16'hFFFF); end
    stat_is("R1 status", 16'h0080);

    // single-word sweep, block 2 locked
    lock_mask = 4'b0100;
    for (int a = 0; a < 64; a++) begin
      logic [15:0] d = ~(16'(a) * 16'h0101) | 16'h8001;
      wr(a, 16'h0040);
      wr(a, d);
      if (a >= 32 && a < 48) begin
        chk("R4 no start", {15'd0, prog_ready}, 16'd1);
        rd(0, v); chk("R4 lock status", v, 16'h0092);
        wr(0, 16'h0050); rd(0, v); chk("R10 cleared", v, 16'h0080);
      end else begin
        model[a] = model[a] & d;
        wait_ready(c); chk("R2 busy cycles", 16'(c), 16'(PC));
        rd(0, v); chk("R3 status view", v, 16'h0080);
      end
      arr_is("R2 word value", a);
    end

    // buffered sweep over every count, aligned base 0
    for (int c2 = 0; c2 < 32; c2++) begin
      buf_run(0, c2, c2, 0, 8'hD0, 1);
      wait_ready(c); chk("R7 busy cycles", 16'(c), 16'((c2 + 1) * PC));
      for (int k = 0; k <= c2; k++) arr_is("R7 word value", k);
    end

    // boundary crossing
    lock_mask = 4'b0000;
    buf_run(24, 3, 5, 0, 8'hD0, 1);  wait_ready(c); chk("R9 no cross", 16'(c), 16'(4 * PC));
    buf_run(24, 9, 6, 0, 8'hD0, 1);  wait_ready(c); chk("R9 cross", 16'(c), 16'(20 * PC));
    buf_run(30, 1, 7, 0, 8'hD0, 1);  wait_ready(c); chk("R9 edge 30", 16'(c), 16'(2 * PC));
    buf_run(31, 1, 8, 0, 8'hD0, 1);  wait_ready(c); chk("R9 edge 31", 16'(c), 16'(4 * PC));
    arr_is("R9 value", 32);

    // count too large
    wr(0, 16'h00E8); wr(0, 16'h0020);
    chk("R6 no start", {15'd0, prog_ready}, 16'd1);
    stat_is("R6 status", 16'h00B0);
    arr_is("R6 unchanged", 0);
    wr(0, 16'h0050); stat_is("R10 clear", 16'h0080);

    // wrong confirm and out-of-range address
    buf_run(4, 1, 9, 0, 8'hFF, 0);
    chk("R8 no start", {15'd0, prog_ready}, 16'd1);
    stat_is("R8 wrong confirm", 16'h00B0);
    arr_is("R8 unchanged", 4);
    stat_is("R10 sticky", 16'h00B0);
    wr(0, 16'h0050);
    buf_run(8, 1, 10, 4, 8'hD0, 0);
    stat_is("R8 range", 16'h00B0);
    arr_is("R8 range unchanged", 12);
    wr(0, 16'h0050);

    // locked word in buffer
    lock_mask = 4'b0100;
    buf_run(46, 3, 11, 0, 8'hD0, 0);
    chk("R12 no start", {15'd0, prog_ready}, 16'd1);
    stat_is("R12 status", 16'h0092);
    arr_is("R12 unchanged", 47);
    wr(0, 16'h0050);
    lock_mask = 4'b0000;

    // setup while busy
    wr(1, 16'h0040); wr(1, 16'h7FFF); model[1] = model[1] & 16'h7FFF;
    wr(0, 16'h00E8); rd(0, v); chk("R5 bit7 low", v, 16'h0000);
    wait_ready(c);
    wr(5, 16'h0005);
    stat_is("R5 ignored", 16'h0080);
    arr_is("R5 array", 5);
    arr_is("R5 array", 1);

    // array read during programming
    wr(2, 16'h0040); wr(2, 16'hBFFF); model[2] = model[2] & 16'hBFFF;
    wr(0, 16'h00FF); rd(2, v); chk("R11 busy read", v, 16'h0000);
    wait_ready(c); rd(2, v); chk("R11 after", v, model[2]);

    // reset abort
    buf_run(0, 31, 3, 0, 8'hD0, 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 abort ready", {15'd0, prog_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 64; a += 7) begin rd(a, v); chk("R1 after abort", v, 16'hFFFF); end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule